// File: doc/BRIEF.md
# Systolic Dot-Product Processing Element

This block is one cell of a systolic matrix-multiply grid. On every cycle marked valid it takes a vector of signed lanes arriving from the west and a vector arriving from the north. It multiplies the two vectors lane by lane and adds all the products to a running partial sum in a single step. The partial sums sit in a rotating ring of entries. The entry that leaves the ring on a given step is the one that re-enters it, updated, that many valid steps later. This lets a grid interleave several independent output tiles through one cell without any pipeline bubbles.

The west vector carries a restart flag. When the flag is set, the entry that leaves the ring is handed out on the drain port as a finished result, and the new sum starts from zero rather than from that entry. Both operand streams are passed on unchanged, through a fixed two-register delay, to the east and south neighbours. The west vector keeps its flag and its valid bit on that path, and the north vector keeps its valid bit.

The data interfaces are valid-only streams with no back-pressure. The cell accepts a step on every cycle where `in_vld` is high, and it has no ready output. Forwarded and drained data must be taken by the receiver in the cycle they are presented. Arithmetic is two's-complement fixed point. It wraps modulo 2^ACC_W.

Top module: `sdp_cell`

## Requirements
- R1: After reset, `drn_vld`, `east_vld` and `south_vld` are low, `drn_sum` is zero, and every ring entry is zero, so the first ACC_N restart steps drain zero.
- R2: Lane i of each vector occupies bits [i*OP_W +: OP_W] and is signed two's complement. A valid step adds the sum of all VEC lane products a_i*b_i to its start value in a single step.
- R3: The ring holds ACC_N partial sums. The sum written by a valid step is the start value of the ACC_N-th following valid step.
- R4: A valid step with `a_clr` high starts from zero. One cycle later it sets `drn_vld` high for exactly one cycle and shows the entry that left the ring on `drn_sum`.
- R5: A valid step with `a_clr` low continues from the leaving entry and leaves `drn_vld` low on the following cycle.
- R6: A cycle with `in_vld` low changes no ring entry and raises no drain, whatever the other inputs hold.
- R7: `east_vld`, `east_clr` and `east_vec` equal `in_vld`, `a_clr` and `a_vec` of two clock edges earlier, on every cycle.
- R8: `south_vld` and `south_vec` equal `in_vld` and `b_vec` of two clock edges earlier, on every cycle.
- R9: Partial sums wrap modulo 2^ACC_W with no saturation.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_vld | input | 1 | Step valid for both operand vectors |
| a_clr | input | 1 | Restart flag carried with the west vector |
| a_vec | input | VEC*OP_W | West operand vector |
| b_vec | input | VEC*OP_W | North operand vector |
| east_vld | output | 1 | Forwarded west valid |
| east_clr | output | 1 | Forwarded restart flag |
| east_vec | output | VEC*OP_W | Forwarded west vector |
| south_vld | output | 1 | Forwarded north valid |
| south_vec | output | VEC*OP_W | Forwarded north vector |
| drn_vld | output | 1 | Drained result valid, one-cycle pulse |
| drn_sum | output | ACC_W | Drained partial sum |

## Verification
The bench builds the cell with VEC=2, OP_W=4, ACC_N=3 and ACC_W=9. That is the smallest accumulator that holds one full step, so every pair of lane-0 operand values can be swept exhaustively, with lane 1 derived from them. With three ring slots, the interleaving and the restart draining are exercised many times over. The narrow accumulator also brings wrap-around within reach: a few steps of the most negative operands overflow it. Idle steps that carry a set flag and nonzero data are mixed into the sweep, and every step also checks the two-register forwarding against the inputs of the previous step.

// File: rtl/sdp_pkg.sv
package sdp_pkg;

  // Smallest accumulator that can hold one full step without loss.
  function automatic int min_acc_width(input int op_w, input int vec);
    return 2 * op_w + $clog2(vec);
  endfunction

endpackage

// File: rtl/sdp_dot.sv
module sdp_dot #(
  parameter int VEC   = 4,
  parameter int OP_W  = 8,
  parameter int ACC_W = 24
) (
  input  logic [VEC*OP_W-1:0] a_vec,
  input  logic [VEC*OP_W-1:0] b_vec,
  output logic [ACC_W-1:0]    dot
);
  localparam int PROD_W = 2 * OP_W;

  logic signed [PROD_W-1:0] prod [VEC];

  for (genvar g = 0; g < VEC; g++) begin : g_lane
    logic signed [OP_W-1:0] al, bl;
    assign al = a_vec[g*OP_W +: OP_W];
    assign bl = b_vec[g*OP_W +: OP_W];
    assign prod[g] = PROD_W'(al) * PROD_W'(bl);
  end

  // Adder tree flattened into one combinational reduction.
  always_comb begin
    logic signed [ACC_W-1:0] s;
    s = '0;
    for (int i = 0; i < VEC; i++) s = s + ACC_W'(prod[i]);
    dot = s;
  end
endmodule

// File: rtl/sdp_ring.sv
module sdp_ring #(
  parameter int ACC_N = 4,
  parameter int ACC_W = 24
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             step,
  input  logic             restart,
  input  logic [ACC_W-1:0] dot,
  output logic [ACC_W-1:0] oldest
);
  logic [ACC_W-1:0] ring [ACC_N];
  logic [ACC_W-1:0] base;

  assign oldest = ring[0];
  assign base   = restart ? '0 : ring[0];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < ACC_N; i++) ring[i] <= '0;
    end else if (step) begin
      for (int i = 0; i < ACC_N - 1; i++) ring[i] <= ring[i+1];
      ring[ACC_N-1] <= base + dot;
    end
  end

  // R6: an idle cycle leaves the leaving entry untouched
  a_r6_idle_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !step |=> $stable(oldest));
endmodule

// File: rtl/sdp_fwd.sv
module sdp_fwd #(
  parameter int W     = 8,
  parameter int DEPTH = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] stg [DEPTH];

  for (genvar k = 0; k < DEPTH; k++) begin : g_stage
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      stg[k] <= '0;
      else if (k == 0) stg[k] <= d;
      else             stg[k] <= stg[(k == 0) ? 0 : k-1];
    end
  end

  assign q = stg[DEPTH-1];
endmodule

// File: rtl/sdp_cell.sv
module sdp_cell #(
  parameter int VEC   = 4,
  parameter int OP_W  = 8,
  parameter int ACC_N = 4,
  parameter int ACC_W = 24,
  parameter int FWD_D = 2
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                in_vld,
  input  logic                a_clr,
  input  logic [VEC*OP_W-1:0] a_vec,
  input  logic [VEC*OP_W-1:0] b_vec,
  output logic                east_vld,
  output logic                east_clr,
  output logic [VEC*OP_W-1:0] east_vec,
  output logic                south_vld,
  output logic [VEC*OP_W-1:0] south_vec,
  output logic                drn_vld,
  output logic [ACC_W-1:0]    drn_sum
);
  import sdp_pkg::*;

  localparam int VW    = VEC * OP_W;
  localparam int MIN_W = min_acc_width(OP_W, VEC);

  logic [ACC_W-1:0] dot;
  logic [ACC_W-1:0] oldest;
  logic             drain_now;

  assign drain_now = in_vld & a_clr;

  sdp_dot #(.VEC(VEC), .OP_W(OP_W), .ACC_W(ACC_W)) u_dot (
    .a_vec(a_vec), .b_vec(b_vec), .dot(dot)
  );

  sdp_ring #(.ACC_N(ACC_N), .ACC_W(ACC_W)) u_ring (
    .clk(clk), .rst_n(rst_n), .step(in_vld), .restart(a_clr),
    .dot(dot), .oldest(oldest)
  );

  sdp_fwd #(.W(VW + 2), .DEPTH(FWD_D)) u_east (
    .clk(clk), .rst_n(rst_n),
    .d({in_vld, a_clr, a_vec}),
    .q({east_vld, east_clr, east_vec})
  );

  sdp_fwd #(.W(VW + 1), .DEPTH(FWD_D)) u_south (
    .clk(clk), .rst_n(rst_n),
    .d({in_vld, b_vec}),
    .q({south_vld, south_vec})
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      drn_vld <= 1'b0;
      drn_sum <= '0;
    end else begin
      drn_vld <= drain_now;
      if (drain_now) drn_sum <= oldest;
    end
  end

  initial begin
    a_width_ok: assert (ACC_W >= MIN_W);
  end

  // R4: a drain pulse is caused only by a valid restart step
  a_r4_drain_cause: assert property (@(posedge clk) disable iff (!rst_n)
    drn_vld |-> $past(in_vld && a_clr));

  // R5: a valid continuing step never drains
  a_r5_no_drain_on_acc: assert property (@(posedge clk) disable iff (!rst_n)
    (in_vld && !a_clr) |=> !drn_vld);

  // R7: east valid rises only two edges after an accepted step
  a_r7_east_follow: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(east_vld) |-> $past(in_vld, 2));

  // R8: both forwarding paths stay aligned
  a_r8_paths_aligned: assert property (@(posedge clk) disable iff (!rst_n)
    south_vld == east_vld);
endmodule

// File: tb/test_sdp_cell.sv
`timescale 1ns/1ps
module test_sdp_cell;
  localparam int VEC   = 2;
  localparam int OP_W  = 4;
  localparam int ACC_N = 3;
  localparam int ACC_W = 9;
  localparam int VW    = VEC * OP_W;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic in_vld = 1'b0, a_clr = 1'b0;
  logic [VW-1:0] a_vec = '0, b_vec = '0;
  logic east_vld, east_clr, south_vld, drn_vld;
  logic [VW-1:0] east_vec, south_vec;
  logic [ACC_W-1:0] drn_sum;

  int n_chk = 0;
  int n_fail = 0;

  logic [ACC_W-1:0] mring [ACC_N];
  logic          p_vld = 1'b0, p_clr = 1'b0;
  logic [VW-1:0] p_a = '0, p_b = '0;

  always #2.5 clk = ~clk;

  sdp_cell #(.VEC(VEC), .OP_W(OP_W), .ACC_N(ACC_N), .ACC_W(ACC_W)) i_sdp_cell (
    .clk(clk), .rst_n(rst_n), .in_vld(in_vld), .a_clr(a_clr),
    .a_vec(a_vec), .b_vec(b_vec),
    .east_vld(east_vld), .east_clr(east_clr), .east_vec(east_vec),
    .south_vld(south_vld), .south_vec(south_vec),
    .drn_vld(drn_vld), .drn_sum(drn_sum)
  );

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  // One clock: drive at a falling edge, check at the next falling edge.
  task automatic step(input bit v, input bit c, input int a0, input int a1,
                      input int b0, input int b1);
    logic [ACC_W-1:0] old, nxt;
    int p;
    in_vld = v; a_clr = c;
    a_vec = {OP_W'(a1), OP_W'(a0)};
    b_vec = {OP_W'(b1), OP_W'(b0)};
    p = a0 * b0 + a1 * b1;
    old = mring[0];
    nxt = (c ? '0 : mring[0]) + ACC_W'(p);
    if (v) begin
      for (int i = 0; i < ACC_N - 1; i++) mring[i] = mring[i+1];
      mring[ACC_N-1] = nxt;
    end
    @(negedge clk);
    chk(drn_vld == (v && c), "R4 R5 R6 drain flag", drn_vld, v && c);
    if (v && c) chk(drn_sum == old, "R2 R3 R9 drained sum", drn_sum, old);
    chk({east_vld, east_clr, east_vec} == {p_vld, p_clr, p_a}, "R7 east forward",
        {east_vld, east_clr, east_vec}, {p_vld, p_clr, p_a});
    chk({south_vld, south_vec} == {p_vld, p_b}, "R8 south forward",
        {south_vld, south_vec}, {p_vld, p_b});
    p_vld = v; p_clr = c; p_a = a_vec; p_b = b_vec;
  endtask

  initial begin
    #(5.0 * 190000);
    n_fail++;
    $display("FAIL watchdog expired");
    $display("  End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    for (int i = 0; i < ACC_N; i++) mring[i] = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R1: reset state
    chk(!drn_vld && !east_vld && !south_vld, "R1 outputs low", {drn_vld, east_vld, south_vld}, 0);
    chk(drn_sum == '0, "R1 drain sum zero", drn_sum, 0);
    // R1: cleared ring drains zeros
    for (int i = 0; i < ACC_N; i++) begin
      step(1, 1, 0, 0, 0, 0);
      chk(drn_sum == '0, "R1 ring cleared", drn_sum, 0);
    end
    // R2 R3 R4 R5 R6: exhaustive lane-0 sweep with derived lane 1
    for (int a0 = -8; a0 < 8; a0++) begin
      for (int b0 = -8; b0 < 8; b0++) begin
        int a1, b1, idx;
        bit c, v;
        idx = (a0 + 8) * 16 + (b0 + 8);
        a1 = ((a0 * 3 + b0) & 15) - 8;
        b1 = ((b0 * 5 + 7) & 15) - 8;
        c  = ((a0 + b0) & 3) == 0;
        v  = (idx % 7) != 3;
        step(v, v ? c : 1'b1, a0, a1, b0, b1);
      end
    end
    // R9: wrap-around of the narrow accumulator
    for (int i = 0; i < ACC_N; i++) step(1, 1, 0, 0, 0, 0);
    for (int i = 0; i < 2 * ACC_N; i++) step(1, 0, -8, -8, -8, -8);
    for (int i = 0; i < ACC_N; i++) begin
      step(1, 1, 0, 0, 0, 0);
      chk(drn_sum == 9'h100, "R9 wrapped sum", drn_sum, 9'h100);
    end
    // R6: idle cycles with flag and data set leave the ring alone
    step(1, 1, 3, 2, 5, -4);
    step(1, 1, 1, 1, 1, 1);
    step(1, 1, -2, 7, 6, 6);
    for (int i = 0; i < 4; i++) step(0, 1, 7, 7, 7, 7);
    for (int i = 0; i < ACC_N; i++) step(1, 1, 0, 0, 0, 0);
    step(0, 0, 0, 0, 0, 0);
    step(0, 0, 0, 0, 0, 0);
    $display("  End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule